// File: doc/BRIEF.md
# Serial Management Slave with Interrupt Request

This block is the device side of the two-wire management bus used by Ethernet transceivers. A host drives a clock line and a bidirectional data line. The block watches both from its own system clock, picks out read and write frames, and serves a bank of 32 registers of 16 bits each. On a read it takes over the data line for the turnaround's second bit and the data bits that follow, through a separate output value and output enable. The surrounding pad logic turns these into a tri-state pin.

A one-bit strap input sets the device address to 0 or 1. A disable input makes the block ignore every frame, whether read or write. Register 18 holds a global interrupt enable in bit 1 and a per-event mask in bits 7:4. Register 19 holds sticky status bits in bits 7:4. Each bit is set by a pulse on an event input and all of them clear when register 19 is read. The active-low interrupt output is low while the global enable is set and at least one status bit is set whose mask bit is also set.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A write frame sent to this device stores its 16 data bits, taken MSB first, into the addressed register. A later read frame to that register returns the same 16 bits, MSB first.
- R2: In a read frame the block does not drive during the first turnaround bit. It drives 0 during the second turnaround bit, then drives 16 data bits with `mdio_oe` high. It releases the line (`mdio_oe` low) from the bit period after D0.
- R3: The block answers only frames whose 5-bit device address equals `{4'b0000, addr_strap}`. For any other address it never drives and never writes.
- R4: While `port_dis` is high, frames are ignored: no register changes and `mdio_oe` stays low.
- R5: A frame is accepted only after at least 32 consecutive ones on the data line. With only 31 ones before the start code, the frame is dropped.
- R6: The start code must be 0 then 1, and the opcode must be 1,0 (read) or 0,1 (write). Any other start code or opcode aborts the frame, and the block waits for a new preamble.
- R7: A one-cycle pulse on `evt[i]` sets bit 4+i of register 19. Bits of register 19 outside 7:4 read as 0, and writes to register 19 have no effect.
- R8: `int_n` is low exactly when register 18 bit 1 is 1 and, for some i, both register 19 bit 4+i and register 18 bit 4+i are 1.
- R9: A read of register 19 returns the status bits that are set, then clears them. An event arriving in the same cycle as the clear stays set.
- R10: After reset every register reads 0, `int_n` is high and `mdio_oe` is low.
- R11: `mdio_oe` is never high during a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the management clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the host |
| mdio_in | input | 1 | Value seen on the management data line |
| mdio_out | output | 1 | Value the block drives onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line (high = drive) |
| addr_strap | input | 1 | Selects device address 0 (low) or 1 (high) |
| port_dis | input | 1 | High: ignore all management frames |
| evt | input | 4 | Event pulses that set the status bits of register 19 |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `port_dis` and `addr_strap` change only between frames. They also assume that the management clock stays high for at least one system clock and low for at least one, and that `mdio_in` changes only while `mdc` is low. The bench spends four system clocks on each bit period, two low and two high. It moves the data line only at the start of the low phase, and it changes the strap, the disable input and the event pulses only between whole frames. With these conditions the strobe and drive-enable properties can rely on the address match decided at the end of the register address field.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants and the frame-state type for the management slave.
// Assumes the 16-bit, 32-register layout with interrupt control in 18 and status in 19.
package mdio_mgmt_pkg;
    localparam int MM_DATA_W   = 16;
    localparam int MM_NREG     = 32;
    localparam int MM_AW       = 5;
    localparam int MM_PRE_LEN  = 32;
    localparam int MM_N_EVT    = 4;
    localparam int MM_EN_REG   = 18;
    localparam int MM_STAT_REG = 19;
    localparam int MM_GLB_BIT  = 1;
    localparam int MM_EVT_LSB  = 4;

    typedef enum logic [2:0] {
        FR_PRE,
        FR_ST,
        FR_OP,
        FR_PHY,
        FR_REG,
        FR_TA,
        FR_DATA
    } fr_state_t;
endpackage

// File: rtl/mdc_edge.sv
// Module: mdc_edge
// Detects rising edges of the management clock in the system clock domain and
// passes the data line through for sampling on that edge.
// Assumes mdc and mdio_in are already synchronous to clk.
module mdc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic tick,
    output logic bit_s
);
    logic mdc_q;

    // Purpose: remember the previous management clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc;
    end

    assign tick  = mdc & ~mdc_q;
    assign bit_s = mdio_in;
endmodule

// File: rtl/mdio_frame.sv
// Module: mdio_frame
// Walks through preamble, start, opcode, device address, register address,
// turnaround and data. Issues read and write strobes to the register bank and
// shifts read data out one bit per management clock.
// Assumes tick marks each rising edge of the management clock.
module mdio_frame import mdio_mgmt_pkg::*; #(
    parameter int DATA_W  = MM_DATA_W,
    parameter int AW      = MM_AW,
    parameter int PRE_LEN = MM_PRE_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bit_i,
    input  logic              strap,
    input  logic              port_dis,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [AW-1:0]     reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              is_rd,
    output logic              hit
);
    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int CW  = (DATA_W > AW) ? $clog2(DATA_W) : $clog2(AW);

    fr_state_t         state;
    logic [PCW-1:0]    pre_cnt;
    logic [CW-1:0]     cnt;
    logic              op_q;
    logic [AW-1:0]     phy_q;
    logic [AW-1:0]     reg_q;
    logic [DATA_W-1:0] sh;
    logic [AW-1:0]     own_addr;

    assign own_addr = {{(AW-1){1'b0}}, strap};
    assign reg_addr = reg_q;
    assign rd_stb   = tick && (state == FR_TA) && (cnt == '0) && hit && is_rd;
    assign wr_stb   = tick && (state == FR_DATA) && (cnt == CW'(DATA_W-1)) && hit && !is_rd;
    assign wr_data  = {sh[DATA_W-2:0], bit_i};

    // Purpose: frame state machine, one step per management clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FR_PRE;
            pre_cnt  <= '0;
            cnt      <= '0;
            op_q     <= 1'b0;
            phy_q    <= '0;
            reg_q    <= '0;
            is_rd    <= 1'b0;
            hit      <= 1'b0;
            sh       <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
        end else if (tick) begin
            case (state)
                FR_PRE: begin
                    if (bit_i) begin
                        if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
                    end else begin
                        if (pre_cnt == PCW'(PRE_LEN)) state <= FR_ST;
                        pre_cnt <= '0;
                    end
                end
                FR_ST: begin
                    cnt   <= '0;
                    state <= bit_i ? FR_OP : FR_PRE;
                end
                FR_OP: begin
                    if (cnt == '0) begin
                        op_q <= bit_i;
                        cnt  <= CW'(1);
                    end else begin
                        cnt <= '0;
                        if (op_q != bit_i) begin
                            is_rd <= op_q;
                            state <= FR_PHY;
                        end else begin
                            state <= FR_PRE;
                        end
                    end
                end
                FR_PHY: begin
                    phy_q <= {phy_q[AW-2:0], bit_i};
                    if (cnt == CW'(AW-1)) begin
                        cnt   <= '0;
                        state <= FR_REG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_REG: begin
                    reg_q <= {reg_q[AW-2:0], bit_i};
                    if (cnt == CW'(AW-1)) begin
                        cnt   <= '0;
                        hit   <= (phy_q == own_addr) && !port_dis;
                        state <= FR_TA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_TA: begin
                    if (cnt == '0) begin
                        cnt <= CW'(1);
                        if (hit && is_rd) begin
                            mdio_oe  <= 1'b1;
                            mdio_out <= 1'b0;
                            sh       <= rd_data;
                        end
                    end else begin
                        cnt      <= '0;
                        mdio_out <= sh[DATA_W-1];
                        sh       <= {sh[DATA_W-2:0], bit_i};
                        state    <= FR_DATA;
                    end
                end
                FR_DATA: begin
                    mdio_out <= sh[DATA_W-1];
                    sh       <= {sh[DATA_W-2:0], bit_i};
                    if (cnt == CW'(DATA_W-1)) begin
                        cnt     <= '0;
                        mdio_oe <= 1'b0;
                        pre_cnt <= '0;
                        state   <= FR_PRE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= FR_PRE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_regfile.sv
// Module: mdio_regfile
// Register bank with one word per address, a read-only sticky status word that
// clears on read, and the active-low interrupt request.
// Assumes rd_stb and wr_stb are single-cycle strobes.
module mdio_regfile import mdio_mgmt_pkg::*; #(
    parameter int DATA_W   = MM_DATA_W,
    parameter int NREG     = MM_NREG,
    parameter int AW       = MM_AW,
    parameter int N_EVT    = MM_N_EVT,
    parameter int EN_REG   = MM_EN_REG,
    parameter int STAT_REG = MM_STAT_REG,
    parameter int GLB_BIT  = MM_GLB_BIT,
    parameter int EVT_LSB  = MM_EVT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_EVT-1:0]  evt,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] en_word,
    output logic [N_EVT-1:0]  stat_bits,
    output logic              int_n
);
    logic [NREG-1:0][DATA_W-1:0] word;
    logic [DATA_W-1:0]           stat_view;
    logic                        stat_rd;

    assign stat_rd = rd_stb && (addr == AW'(STAT_REG));

    // Purpose: sticky status bits; a status read clears, new events always win.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_bits <= '0;
        else if (stat_rd) stat_bits <= evt;
        else              stat_bits <= stat_bits | evt;
    end

    // Purpose: place the status bits at their field position in the read word.
    always_comb begin
        stat_view = '0;
        stat_view[EVT_LSB +: N_EVT] = stat_bits;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == STAT_REG) begin : g_stat
            assign word[i] = stat_view;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            // Purpose: writable storage word for address i.
            always_ff @(posedge clk) begin
                if (!rst_n)                             q <= '0;
                else if (wr_stb && addr == AW'(i))      q <= wr_data;
            end
            assign word[i] = q;
        end
    end

    assign rd_data = word[addr];
    assign en_word = word[EN_REG];
    assign int_n   = ~(en_word[GLB_BIT] & (|(stat_bits & en_word[EVT_LSB +: N_EVT])));
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Module: mdio_mgmt_slave (top)
// Serial management slave: edge detection, frame decoding and the register bank
// with interrupt request. The data line is split into value and enable.
// Assumes all inputs are synchronous to clk.
module mdio_mgmt_slave import mdio_mgmt_pkg::*; #(
    parameter int DATA_W = MM_DATA_W,
    parameter int N_EVT  = MM_N_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mdc,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             addr_strap,
    input  logic             port_dis,
    input  logic [N_EVT-1:0] evt,
    output logic             int_n
);
    localparam int AW = MM_AW;

    logic              tick;
    logic              bit_s;
    logic              rd_stb;
    logic              wr_stb;
    logic [AW-1:0]     reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] en_word;
    logic [N_EVT-1:0]  stat_bits;
    logic              is_rd;
    logic              hit;

    mdc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_in),
        .tick    (tick),
        .bit_s   (bit_s)
    );

    mdio_frame #(.DATA_W(DATA_W), .AW(AW), .PRE_LEN(MM_PRE_LEN)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bit_i    (bit_s),
        .strap    (addr_strap),
        .port_dis (port_dis),
        .rd_data  (rd_data),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .is_rd    (is_rd),
        .hit      (hit)
    );

    mdio_regfile #(.DATA_W(DATA_W), .NREG(MM_NREG), .AW(AW), .N_EVT(N_EVT),
                   .EN_REG(MM_EN_REG), .STAT_REG(MM_STAT_REG),
                   .GLB_BIT(MM_GLB_BIT), .EVT_LSB(MM_EVT_LSB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .evt       (evt),
        .rd_data   (rd_data),
        .en_word   (en_word),
        .stat_bits (stat_bits),
        .int_n     (int_n)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Module: mdio_mgmt_chk
// Property checker bound to the top. Assumes port_dis and addr_strap change
// only between frames.
module mdio_mgmt_chk import mdio_mgmt_pkg::*; (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mdio_oe,
    input logic                 mdio_out,
    input logic                 port_dis,
    input logic [MM_N_EVT-1:0]  evt,
    input logic                 int_n,
    input logic                 rd_stb,
    input logic                 wr_stb,
    input logic [MM_AW-1:0]     reg_addr,
    input logic                 is_rd,
    input logic                 hit,
    input logic [MM_DATA_W-1:0] en_word,
    input logic [MM_N_EVT-1:0]  stat_bits
);
    p_ta_drives_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    p_no_drive_in_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (is_rd && hit));

    p_write_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (hit && !is_rd));

    p_disable_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> !port_dis);

    p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_bits & $past(evt)) == $past(evt)));

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_addr == MM_AW'(MM_STAT_REG) && evt == '0) |=> (stat_bits == '0));

    p_int_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> en_word[MM_GLB_BIT]);

    p_int_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> ((stat_bits & en_word[MM_EVT_LSB +: MM_N_EVT]) != '0));
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .port_dis  (port_dis),
    .evt       (evt),
    .int_n     (int_n),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .reg_addr  (reg_addr),
    .is_rd     (is_rd),
    .hit       (hit),
    .en_word   (en_word),
    .stat_bits (stat_bits)
);

// File: tb/test_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module test_mdio_mgmt_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdc = 1'b0;
    logic       mdio_in = 1'b1;
    logic       mdio_out;
    logic       mdio_oe;
    logic       addr_strap = 1'b0;
    logic       port_dis = 1'b0;
    logic [3:0] evt = '0;
    logic       int_n;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic s_oe, s_out;
    logic [15:0] model [32];
    logic [3:0]  stat_m;

    always #4 clk = ~clk;

    mdio_mgmt_slave i_mdio_mgmt_slave (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .addr_strap(addr_strap),
        .port_dis(port_dis), .evt(evt), .int_n(int_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bit period: 2 clocks low (sample at end), 2 clocks high
    task automatic send_bit(input logic b);
        mdc = 1'b0;
        mdio_in = b;
        repeat (2) @(negedge clk);
        s_oe  = mdio_oe;
        s_out = mdio_out;
        mdc = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_head(input int pre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(st[1]); send_bit(st[0]);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    task automatic mdio_write(input int pre, input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d,
                              output bit any_oe);
        any_oe = 0;
        send_head(pre, st, op, phy, ra);
        send_bit(1'b1); any_oe |= s_oe;
        send_bit(1'b0); any_oe |= s_oe;
        for (int i = 15; i >= 0; i--) begin
            send_bit(d[i]); any_oe |= s_oe;
        end
    endtask

    task automatic mdio_read(input logic [4:0] phy, input logic [4:0] ra,
                             output logic [15:0] d, output bit tmg_ok, output bit any_oe);
        tmg_ok = 1; any_oe = 0; d = '0;
        send_head(32, 2'b01, 2'b10, phy, ra);
        send_bit(1'b1); any_oe |= s_oe;
        if (s_oe !== 1'b0) tmg_ok = 0;
        send_bit(1'b1); any_oe |= s_oe;
        if (s_oe !== 1'b1 || s_out !== 1'b0) tmg_ok = 0;
        for (int i = 0; i < 16; i++) begin
            send_bit(1'b1); any_oe |= s_oe;
            if (s_oe !== 1'b1) tmg_ok = 0;
            d = {d[14:0], s_out};
        end
        send_bit(1'b1);
        if (s_oe !== 1'b0) tmg_ok = 0;
        any_oe |= s_oe;
    endtask

    function automatic logic [15:0] pat(input int r, input int s);
        return 16'((r * 16'h0b3d) ^ 16'h5a96 ^ (s * 16'h1111));
    endfunction

    function automatic logic [15:0] exp_rd(input int r);
        return (r == 19) ? {8'h00, stat_m, 4'h0} : model[r];
    endfunction

    function automatic logic exp_int();
        return !(model[18][1] && ((stat_m & model[18][7:4]) != 4'h0));
    endfunction

    task automatic pulse_evt(input logic [3:0] v);
        evt = v;
        @(negedge clk);
        evt = '0;
        stat_m |= v;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        bit tmg, oe_seen;
        for (int i = 0; i < 32; i++) model[i] = '0;
        stat_m = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(int_n === 1'b1, "R10 int_n after reset", {31'b0, int_n}, 1);
        chk(mdio_oe === 1'b0, "R10 oe after reset", {31'b0, mdio_oe}, 0);
        mdio_read(5'd0, 5'd7, d, tmg, oe_seen);
        chk(d === 16'h0000, "R10 register reads zero", d, 0);
        chk(tmg, "R2 read timing after reset", tmg, 1);

        // R1/R3/R7 sweep over both straps and all registers
        for (int s = 0; s < 2; s++) begin
            addr_strap = s[0];
            for (int r = 0; r < 32; r++) begin
                mdio_write(32, 2'b01, 2'b01, 5'(s), 5'(r), pat(r, s), oe_seen);
                chk(!oe_seen, "R11 no drive during write", oe_seen, 0);
                if (r != 19) model[r] = pat(r, s);
            end
            for (int r = 0; r < 32; r++) begin
                logic [4:0] other;
                other = (r % 2 == 0) ? 5'(s ^ 1) : (5'h10 | 5'(s));
                mdio_write(32, 2'b01, 2'b01, other, 5'(r), ~pat(r, s), oe_seen);
            end
            for (int r = 0; r < 32; r++) begin
                mdio_read(5'(s), 5'(r), d, tmg, oe_seen);
                if (r == 19) chk(d === exp_rd(r), "R7 status word ignores writes", d, exp_rd(r));
                else         chk(d === exp_rd(r), "R1 R3 readback", d, exp_rd(r));
                chk(tmg, "R2 turnaround and release timing", tmg, 1);
            end
            mdio_read(5'(s ^ 1), 5'd0, d, tmg, oe_seen);
            chk(!oe_seen, "R3 other address not answered", oe_seen, 0);
            mdio_read(5'h1F, 5'd31, d, tmg, oe_seen);
            chk(!oe_seen, "R3 high address not answered", oe_seen, 0);
        end

        // R4 port disable
        port_dis = 1'b1;
        mdio_write(32, 2'b01, 2'b01, 5'd1, 5'd3, 16'h1234, oe_seen);
        mdio_read(5'd1, 5'd3, d, tmg, oe_seen);
        chk(!oe_seen, "R4 no drive while disabled", oe_seen, 0);
        port_dis = 1'b0;
        mdio_read(5'd1, 5'd3, d, tmg, oe_seen);
        chk(d === model[3], "R4 write ignored while disabled", d, model[3]);

        // R5 short preamble
        send_bit(1'b0);
        mdio_write(31, 2'b01, 2'b01, 5'd1, 5'd4, 16'h0f0f, oe_seen);
        mdio_read(5'd1, 5'd4, d, tmg, oe_seen);
        chk(d === model[4], "R5 short preamble ignored", d, model[4]);

        // R6 bad start code and bad opcodes
        send_bit(1'b0);
        mdio_write(32, 2'b00, 2'b01, 5'd1, 5'd5, 16'h0ff0, oe_seen);
        mdio_read(5'd1, 5'd5, d, tmg, oe_seen);
        chk(d === model[5], "R6 bad start code ignored", d, model[5]);
        send_bit(1'b0);
        mdio_write(32, 2'b01, 2'b11, 5'd1, 5'd6, 16'h3c3c, oe_seen);
        send_bit(1'b0);
        mdio_write(32, 2'b01, 2'b00, 5'd1, 5'd6, 16'h4242, oe_seen);
        mdio_read(5'd1, 5'd6, d, tmg, oe_seen);
        chk(d === model[6], "R6 bad opcode ignored", d, model[6]);

        // R7/R8/R9 interrupt sweep
        for (int k = 0; k < 4; k++) begin
            logic [3:0] sp;
            sp = (k == 0) ? 4'h5 : (k == 1) ? 4'hA : (k == 2) ? 4'hF : 4'h3;
            pulse_evt(sp);
            for (int g = 0; g < 2; g++) begin
                for (int m = 0; m < 16; m++) begin
                    logic [15:0] w;
                    w = {8'h00, 4'(m), 4'h0} | {14'h0, 1'(g), 1'b0};
                    mdio_write(32, 2'b01, 2'b01, 5'd1, 5'd18, w, oe_seen);
                    model[18] = w;
                    chk(int_n === exp_int(), "R8 interrupt level", {31'b0, int_n}, {31'b0, exp_int()});
                end
            end
            mdio_read(5'd1, 5'd19, d, tmg, oe_seen);
            chk(d === exp_rd(19), "R7 status bits set by events", d, exp_rd(19));
            stat_m = '0;
            chk(int_n === 1'b1, "R9 interrupt drops after status read", {31'b0, int_n}, 1);
            mdio_read(5'd1, 5'd19, d, tmg, oe_seen);
            chk(d === 16'h0000, "R9 status clears on read", d, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule